// File: doc/BRIEF.md
# SPI Banked Register Command Decoder

This block is the serial front end of a network controller. An external host talks to it over a four-wire SPI link in mode 0. Each chip-select assertion carries one command. The first byte is an opcode. The bytes that follow are data going in, or a response coming out on MISO. The block turns these commands into accesses on a register-file port and a packet-memory port.

The block owns a small set of registers itself: the bank/control byte, the auto-increment control byte, and the buffer read and write pointers. Every other control register address is passed to the register-file port. The bank field on that port is filled in from the current bank selection.

All SPI inputs are resampled by the system clock, so the whole block runs in one clock domain. Each SCK high phase and each SCK low phase must last at least six system clock periods. A soft-reset command restores the owned registers to their reset values. It also pulses a reset strobe towards the register file and holds a clock-ready flag low for a fixed number of cycles.

Top module: `spi_bank_cmd_decoder`

## Requirements
- R1: The first byte after chip select falls is the opcode. Bits 7:5 select the operation and bits 4:0 the register address: 000 reads, 010 writes, 100 sets bits, 101 clears bits. The bytes 0x3A and 0x7A are buffer read and buffer write, and 0xFF is soft reset. Any other first byte makes the whole transaction a no-op, with no register or memory write.
- R2: MOSI is sampled on rising SCK and MISO is driven on falling SCK, most significant bit first. MISO is 0 during the opcode byte. For a register read, every response byte after the opcode carries the register value, until chip select rises.
- R3: A read of a MAC/MII address returns one 0x00 dummy byte before the value. These addresses are bank 2 addresses 0x00 to 0x1A, and bank 3 addresses 0x00 to 0x05 and 0x0A.
- R4: Bits 1:0 of address 0x1F select the bank used for addresses 0x00 to 0x1A; regAddr carries {bank, address}. Addresses 0x1B to 0x1F reach the same register in every bank, and for them regAddr carries bank field 0. Address 0x1F resets to 0x00.
- R5: A write command stores the second byte of the transaction. Any later bytes in the same transaction have no effect.
- R6: Bit-set ORs the second byte into the register and bit-clear clears the bits set in it. On MAC/MII addresses both commands leave the register unchanged.
- R7: After 0x7A, each completed data byte is written to memory at the write pointer. The write pointer advances by one after each byte when auto-increment is on.
- R8: After 0x3A, each response byte is the memory byte at the read pointer. The read pointer advances by one after each byte when auto-increment is on.
- R9: Auto-increment is bit 7 of address 0x1E, and 0x1E resets to 0x80. With the bit clear, neither pointer moves: a buffer write keeps overwriting one location and a buffer read keeps repeating one byte.
- R10: In bank 0 the block owns four registers. Address 0x00 is the read pointer low byte, 0x01 the read pointer high byte, 0x02 the write pointer low byte and 0x03 the write pointer high byte. Pointer bits above PTR_W-1 read as 0 and are dropped on write.
- R11: Soft reset (0xFF) returns 0x1E, 0x1F and both pointers to their reset values, pulses softResetOut for one cycle, and holds clkReady low for RESET_HOLD cycles. The same hold applies after rstN.
- R12: When chip select rises, the command ends. A partly shifted byte is discarded and causes no write. The next transaction starts cleanly with a new opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | SPI data from host |
| csN | input | 1 | SPI chip select, active low |
| miso | output | 1 | SPI data to host |
| regAddr | output | 7 | Register-file address {bank, address} |
| regRdEn | output | 1 | Register-file read strobe, data expected next cycle |
| regRdData | input | 8 | Register-file read data |
| regWrEn | output | 1 | Register-file write strobe |
| regWrData | output | 8 | Register-file write data |
| memAddr | output | PTR_W | Packet-memory address |
| memRdEn | output | 1 | Packet-memory read strobe, data expected next cycle |
| memRdData | input | 8 | Packet-memory read data |
| memWrEn | output | 1 | Packet-memory write strobe |
| memWrData | output | 8 | Packet-memory write data |
| softResetOut | output | 1 | One-cycle pulse asking the register file to reset |
| clkReady | output | 1 | High once the post-reset hold has elapsed |

## Verification
The hardest cases to reach are the ones that depend on the bank/address pairing. The dummy byte and the suppressed bit operations occur only for particular addresses in banks 2 and 3. The bench therefore sweeps every address of every bank: it first writes the bank through address 0x1F, then reads with a three-byte transaction, so both the dummy position and the repeated value show on MISO. Aborted transactions are produced by raising chip select part way through a byte. Pointer behaviour without auto-increment is reached by clearing bit 7 of 0x1E between buffer transfers.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;

  localparam int ADDR_W = 5;
  localparam int BANK_W = 2;

  localparam logic [2:0] OP_READ  = 3'b000;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_SET   = 3'b100;
  localparam logic [2:0] OP_CLEAR = 3'b101;

  localparam logic [7:0] BYTE_BUF_READ  = 8'h3A;
  localparam logic [7:0] BYTE_BUF_WRITE = 8'h7A;
  localparam logic [7:0] BYTE_RESET     = 8'hFF;

  localparam logic [ADDR_W-1:0] ADDR_SHARED_BASE = 5'h1B;
  localparam logic [ADDR_W-1:0] ADDR_AUTO_CTRL   = 5'h1E;
  localparam logic [ADDR_W-1:0] ADDR_BANK_CTRL   = 5'h1F;
  localparam logic [7:0]        AUTO_CTRL_RESET  = 8'h80;

  typedef enum logic [2:0] {
    CMD_IDLE, CMD_RDREG, CMD_WRREG, CMD_BSET, CMD_BCLR,
    CMD_RDBUF, CMD_WRBUF, CMD_SKIP
  } cmd_e;

  typedef enum logic [1:0] { TX_ZERO, TX_REG, TX_MEM } txSrc_e;

  typedef struct packed {
    logic   fetchReg;
    logic   fetchMem;
    logic   commitReg;
    logic   writeMem;
    logic   advRd;
    logic   softReset;
    logic   byteEnd;
    txSrc_e txSrc;
  } strobes_t;

  function automatic logic isMacAddr(input logic [BANK_W-1:0] bank,
                                     input logic [ADDR_W-1:0] a);
    return ((bank == 2'd2) && (a <= 5'h1A)) ||
           ((bank == 2'd3) && ((a <= 5'h05) || (a == 5'h0A)));
  endfunction

endpackage

// File: rtl/spi_bank_front.sv
module spi_bank_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       mosi,
  input  logic       csN,
  output logic       csActive,
  output logic       sckRise,
  output logic       sckFall,
  output logic       byteDone,
  output logic [7:0] rxByte
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sckSync, mosiSync, csSync;
  logic       sckLast;
  logic [2:0] bitCnt;
  logic [6:0] rxShift;
  logic       sckS, mosiS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= '0;
      mosiSync <= '0;
      csSync   <= '1;
    end else begin
      sckSync  <= {sckSync[TOP-1:0], sck};
      mosiSync <= {mosiSync[TOP-1:0], mosi};
      csSync   <= {csSync[TOP-1:0], csN};
    end
  end

  assign sckS     = sckSync[TOP];
  assign mosiS    = mosiSync[TOP];
  assign csActive = ~csSync[TOP];
  assign sckRise  = csActive & sckS & ~sckLast;
  assign sckFall  = csActive & ~sckS & sckLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckLast  <= 1'b0;
      bitCnt   <= '0;
      rxShift  <= '0;
      rxByte   <= '0;
      byteDone <= 1'b0;
    end else begin
      sckLast  <= sckS;
      byteDone <= 1'b0;
      if (!csActive) begin
        bitCnt <= '0;
      end else if (sckRise) begin
        rxShift <= {rxShift[5:0], mosiS};
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) begin
          rxByte   <= {rxShift, mosiS};
          byteDone <= 1'b1;
        end
      end
    end
  end

  // R12: a transaction always begins on a byte boundary
  assert_clean_start_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csActive) |-> (bitCnt == 3'd0));

endmodule

// File: rtl/spi_bank_ctrl.sv
module spi_bank_ctrl
  import spi_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              byteDone,
  input  logic [7:0]        rxByte,
  input  logic [BANK_W-1:0] bank,
  output cmd_e              cmd,
  output logic [ADDR_W-1:0] addr,
  output strobes_t          stb
);
  cmd_e       cmdQ, decoded;
  logic [1:0] byteIdx;
  logic       fetchPend;
  logic       macNow, bitOp, firstByte;

  always_comb begin
    case (rxByte[7:5])
      OP_READ:  decoded = CMD_RDREG;
      OP_WRITE: decoded = CMD_WRREG;
      OP_SET:   decoded = CMD_BSET;
      OP_CLEAR: decoded = CMD_BCLR;
      default: begin
        if (rxByte == BYTE_BUF_READ)       decoded = CMD_RDBUF;
        else if (rxByte == BYTE_BUF_WRITE) decoded = CMD_WRBUF;
        else                               decoded = CMD_SKIP;
      end
    endcase
  end

  assign firstByte = byteDone && (byteIdx == 2'd0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ      <= CMD_IDLE;
      addr      <= '0;
      byteIdx   <= '0;
      fetchPend <= 1'b0;
    end else if (!csActive) begin
      cmdQ      <= CMD_IDLE;
      byteIdx   <= '0;
      fetchPend <= 1'b0;
    end else begin
      fetchPend <= 1'b0;
      if (byteDone) begin
        if (byteIdx == 2'd0) begin
          cmdQ      <= decoded;
          addr      <= rxByte[ADDR_W-1:0];
          byteIdx   <= 2'd1;
          fetchPend <= (decoded == CMD_RDREG) || (decoded == CMD_BSET) ||
                       (decoded == CMD_BCLR)  || (decoded == CMD_RDBUF);
        end else begin
          if (byteIdx != 2'd3) byteIdx <= byteIdx + 2'd1;
          fetchPend <= (cmdQ == CMD_RDBUF);
        end
      end
    end
  end

  assign cmd    = cmdQ;
  assign macNow = isMacAddr(bank, addr);
  assign bitOp  = (cmdQ == CMD_BSET) || (cmdQ == CMD_BCLR);

  always_comb begin
    stb           = '0;
    stb.fetchReg  = fetchPend && ((cmdQ == CMD_RDREG) || bitOp);
    stb.fetchMem  = fetchPend && (cmdQ == CMD_RDBUF);
    stb.commitReg = byteDone && (byteIdx == 2'd1) &&
                    ((cmdQ == CMD_WRREG) || (bitOp && !macNow));
    stb.writeMem  = byteDone && (byteIdx != 2'd0) && (cmdQ == CMD_WRBUF);
    stb.advRd     = byteDone && (byteIdx != 2'd0) && (cmdQ == CMD_RDBUF);
    stb.softReset = firstByte && (rxByte == BYTE_RESET);
    stb.byteEnd   = byteDone;
    case (cmdQ)
      CMD_RDREG: stb.txSrc = (macNow && byteIdx == 2'd1) ? TX_ZERO : TX_REG;
      CMD_RDBUF: stb.txSrc = TX_MEM;
      default:   stb.txSrc = TX_ZERO;
    endcase
  end

  // R8: fetches are always triggered by a completed byte one cycle earlier
  assert_fetch_after_byte_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fetchMem || stb.fetchReg) |-> $past(byteDone));

endmodule

// File: rtl/spi_bank_datapath.sv
module spi_bank_datapath
  import spi_bank_pkg::*;
#(
  parameter int PTR_W      = 13,
  parameter int RESET_HOLD = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              sckFall,
  input  logic [7:0]        rxByte,
  input  cmd_e              cmd,
  input  logic [ADDR_W-1:0] addr,
  input  strobes_t          stb,
  input  logic [7:0]        regRdData,
  input  logic [7:0]        memRdData,
  output logic [BANK_W-1:0] bank,
  output logic              miso,
  output logic [BANK_W+ADDR_W-1:0] regAddr,
  output logic              regRdEn,
  output logic              regWrEn,
  output logic [7:0]        regWrData,
  output logic [PTR_W-1:0]  memAddr,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic              softResetOut,
  output logic              clkReady
);
  localparam int HOLD_W = $clog2(RESET_HOLD + 1);

  logic [7:0]       autoCtrl, bankCtrl, regLatch, memLatch, txShift;
  logic [7:0]       internalVal, curVal, newVal, txNext;
  logic [PTR_W-1:0] rdPtr, wrPtr, ptrStep;
  logic [15:0]      rdPtr16, wrPtr16;
  logic             regLatchPend, memLatchPend, loadPending;
  logic             isShared, isPtr, isInternal, autoInc;
  logic [HOLD_W-1:0] holdCnt;

  assign bank     = bankCtrl[BANK_W-1:0];
  assign autoInc  = autoCtrl[7];
  assign ptrStep  = {{(PTR_W-1){1'b0}}, autoInc};
  assign rdPtr16  = 16'(rdPtr);
  assign wrPtr16  = 16'(wrPtr);

  assign isShared   = (addr >= ADDR_SHARED_BASE);
  assign isPtr      = !isShared && (bank == 2'd0) && (addr <= 5'd3);
  assign isInternal = isPtr || (addr == ADDR_AUTO_CTRL) || (addr == ADDR_BANK_CTRL);

  always_comb begin
    internalVal = 8'h00;
    if (addr == ADDR_AUTO_CTRL)      internalVal = autoCtrl;
    else if (addr == ADDR_BANK_CTRL) internalVal = bankCtrl;
    else if (isPtr) begin
      case (addr[1:0])
        2'd0: internalVal = rdPtr16[7:0];
        2'd1: internalVal = rdPtr16[15:8];
        2'd2: internalVal = wrPtr16[7:0];
        default: internalVal = wrPtr16[15:8];
      endcase
    end
  end

  assign curVal = isInternal ? internalVal : regLatch;

  always_comb begin
    case (cmd)
      CMD_BSET: newVal = curVal | rxByte;
      CMD_BCLR: newVal = curVal & ~rxByte;
      default:  newVal = rxByte;
    endcase
  end

  assign regAddr   = {(isShared ? 2'b00 : bank), addr};
  assign regRdEn   = stb.fetchReg && !isInternal;
  assign regWrEn   = stb.commitReg && !isInternal;
  assign regWrData = newVal;
  assign memAddr   = (cmd == CMD_WRBUF) ? wrPtr : rdPtr;
  assign memRdEn   = stb.fetchMem;
  assign memWrEn   = stb.writeMem;
  assign memWrData = rxByte;

  // owned registers and pointers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      autoCtrl <= AUTO_CTRL_RESET;
      bankCtrl <= '0;
      rdPtr    <= '0;
      wrPtr    <= '0;
    end else if (stb.softReset) begin
      autoCtrl <= AUTO_CTRL_RESET;
      bankCtrl <= '0;
      rdPtr    <= '0;
      wrPtr    <= '0;
    end else begin
      if (stb.commitReg && isInternal) begin
        if (addr == ADDR_AUTO_CTRL)      autoCtrl <= newVal;
        else if (addr == ADDR_BANK_CTRL) bankCtrl <= newVal;
        else begin
          case (addr[1:0])
            2'd0: rdPtr <= PTR_W'({rdPtr16[15:8], newVal});
            2'd1: rdPtr <= PTR_W'({newVal, rdPtr16[7:0]});
            2'd2: wrPtr <= PTR_W'({wrPtr16[15:8], newVal});
            default: wrPtr <= PTR_W'({newVal, wrPtr16[7:0]});
          endcase
        end
      end
      if (stb.writeMem) wrPtr <= wrPtr + ptrStep;
      if (stb.advRd)    rdPtr <= rdPtr + ptrStep;
    end
  end

  // read data capture, one cycle after each strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regLatchPend <= 1'b0;
      memLatchPend <= 1'b0;
      regLatch     <= '0;
      memLatch     <= '0;
    end else begin
      regLatchPend <= regRdEn;
      memLatchPend <= memRdEn;
      if (regLatchPend) regLatch <= regRdData;
      if (memLatchPend) memLatch <= memRdData;
    end
  end

  always_comb begin
    case (stb.txSrc)
      TX_REG:  txNext = curVal;
      TX_MEM:  txNext = memLatch;
      default: txNext = 8'h00;
    endcase
  end

  // MISO shifter: load at the falling edge after a byte boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift     <= '0;
      loadPending <= 1'b0;
    end else if (!csActive) begin
      txShift     <= '0;
      loadPending <= 1'b0;
    end else begin
      if (sckFall) begin
        if (loadPending) begin
          txShift     <= txNext;
          loadPending <= 1'b0;
        end else begin
          txShift <= {txShift[6:0], 1'b0};
        end
      end
      if (stb.byteEnd) loadPending <= 1'b1;
    end
  end

  assign miso = txShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt      <= HOLD_W'(RESET_HOLD);
      softResetOut <= 1'b0;
    end else begin
      softResetOut <= stb.softReset;
      if (stb.softReset)       holdCnt <= HOLD_W'(RESET_HOLD);
      else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;
    end
  end

  assign clkReady = (holdCnt == '0);

  // R11: soft reset drops the ready flag and the bank selection
  assert_hold_after_reset_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.softReset |=> !clkReady);
  assert_bank_cleared_R11: assert property (@(posedge clk) disable iff (!rstN)
    stb.softReset |=> (bank == 2'd0));
  // R7: at most one port access per cycle
  assert_single_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, regRdEn, memWrEn, memRdEn}));
  // R9: write pointer steps by one per buffer byte with auto-increment
  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && autoInc) |=> (wrPtr == $past(wrPtr) + 1'b1));
  // R12: no register write outside a transaction
  assert_write_in_cs_R12: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> csActive);

endmodule

// File: rtl/spi_bank_cmd_decoder.sv
module spi_bank_cmd_decoder
  import spi_bank_pkg::*;
#(
  parameter int PTR_W       = 13,
  parameter int RESET_HOLD  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             mosi,
  input  logic             csN,
  output logic             miso,
  output logic [6:0]       regAddr,
  output logic             regRdEn,
  input  logic [7:0]       regRdData,
  output logic             regWrEn,
  output logic [7:0]       regWrData,
  output logic [PTR_W-1:0] memAddr,
  output logic             memRdEn,
  input  logic [7:0]       memRdData,
  output logic             memWrEn,
  output logic [7:0]       memWrData,
  output logic             softResetOut,
  output logic             clkReady
);
  logic              csActive, sckRise, sckFall, byteDone;
  logic [7:0]        rxByte;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] addr;
  cmd_e              cmd;
  strobes_t          stb;

  spi_bank_front #(.SYNC_STAGES(SYNC_STAGES)) uFront (
    .clk, .rstN, .sck, .mosi, .csN,
    .csActive, .sckRise, .sckFall, .byteDone, .rxByte
  );

  spi_bank_ctrl uCtrl (
    .clk, .rstN, .csActive, .byteDone, .rxByte, .bank,
    .cmd, .addr, .stb
  );

  spi_bank_datapath #(.PTR_W(PTR_W), .RESET_HOLD(RESET_HOLD)) uPath (
    .clk, .rstN, .csActive, .sckFall, .rxByte, .cmd, .addr, .stb,
    .regRdData, .memRdData, .bank, .miso, .regAddr, .regRdEn, .regWrEn,
    .regWrData, .memAddr, .memRdEn, .memWrEn, .memWrData,
    .softResetOut, .clkReady
  );

  // R2: a new bit is only presented after a falling edge or in idle
  assert_miso_on_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csActive && $past(csActive) && !$stable(miso)) |-> $past(sckFall));

endmodule

// File: tb/spi_bank_cmd_decoder_test.sv
`timescale 1ns/1ps
module spi_bank_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int HOLD       = 20;
  localparam int PW         = 13;

  logic clk = 0, rstN = 0, sck = 0, mosi = 0, csN = 1;
  logic miso, regRdEn, regWrEn, memRdEn, memWrEn, softResetOut, clkReady;
  logic [6:0] regAddr;
  logic [7:0] regRdData, regWrData, memRdData, memWrData;
  logic [PW-1:0] memAddr;

  logic [7:0] rf [128];
  logic [7:0] mem [256];
  int total = 0, fails = 0, regWrCount = 0, memWrCount = 0, resetPulses = 0;
  logic [7:0] txBuf [16];
  logic [7:0] rxBuf [16];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_bank_cmd_decoder #(.PTR_W(PW), .RESET_HOLD(HOLD)) uut (
    .clk, .rstN, .sck, .mosi, .csN, .miso, .regAddr, .regRdEn, .regRdData,
    .regWrEn, .regWrData, .memAddr, .memRdEn, .memRdData, .memWrEn,
    .memWrData, .softResetOut, .clkReady
  );

  // storage models
  always @(posedge clk) begin
    if (softResetOut) begin
      for (int i = 0; i < 128; i++) rf[i] <= 8'h00;
      resetPulses <= resetPulses + 1;
    end else if (regWrEn) begin
      rf[regAddr] <= regWrData;
      regWrCount  <= regWrCount + 1;
    end
    if (regRdEn) regRdData <= rf[regAddr];
    if (memWrEn) begin
      mem[memAddr[7:0]] <= memWrData;
      memWrCount <= memWrCount + 1;
    end
    if (memRdEn) memRdData <= mem[memAddr[7:0]];
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendBits(input logic [7:0] b, input int nb, output logic [7:0] got);
    got = 8'h00;
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); mosi = b[7-i];
      repeat (HALF) @(negedge clk);
      got[7-i] = miso;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  task automatic csLow();
    @(negedge clk); csN = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (4) @(negedge clk); csN = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input int n);
    csLow();
    for (int i = 0; i < n; i++) sendBits(txBuf[i], 8, rxBuf[i]);
    csHigh();
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [7:0] v);
    txBuf[0] = {3'b010, a}; txBuf[1] = v; xfer(2);
  endtask

  task automatic rdReg(input logic [4:0] a, output logic [7:0] r1, output logic [7:0] r2);
    txBuf[0] = {3'b000, a}; txBuf[1] = 0; txBuf[2] = 0; xfer(3);
    r1 = rxBuf[1]; r2 = rxBuf[2];
  endtask

  task automatic bitOp(input bit setOp, input logic [4:0] a, input logic [7:0] m);
    txBuf[0] = {(setOp ? 3'b100 : 3'b101), a}; txBuf[1] = m; xfer(2);
  endtask

  function automatic bit macAddr(input int b, input int a);
    return (b == 2 && a <= 'h1A) || (b == 3 && (a <= 5 || a == 'h0A));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] r1, r2, jnk;
    int wc, mc;
    for (int i = 0; i < 128; i++) rf[i] = 8'(i * 37 + 11);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    // R11 reset state
    check("R11 clkReady low after rstN", clkReady, 0);
    check("R2 miso idle", miso, 0);
    repeat (HOLD + 2) @(negedge clk);
    check("R11 clkReady high after hold", clkReady, 1);

    // R4/R3/R2/R10 sweep over all banks and addresses
    for (int b = 0; b < 4; b++) begin
      wrReg(5'h1F, 8'(b));
      for (int a = 0; a < 32; a++) begin
        int exp;
        if (a == 'h1E) exp = 'h80;
        else if (a == 'h1F) exp = b;
        else if (b == 0 && a <= 3) exp = 0;
        else if (a >= 'h1B) exp = rf[a];
        else exp = rf[b * 32 + a];
        rdReg(5'(a), r1, r2);
        if (macAddr(b, a)) begin
          check($sformatf("R3 dummy b%0d a%0h", b, a), r1, 0);
          check($sformatf("R3 value b%0d a%0h", b, a), r2, exp);
        end else begin
          check($sformatf("R4 value b%0d a%0h", b, a), r1, exp);
          check($sformatf("R2 repeat b%0d a%0h", b, a), r2, exp);
        end
      end
    end

    // R5 write, later bytes ignored
    wrReg(5'h1F, 8'd1);
    txBuf[0] = 8'h45; txBuf[1] = 8'hA5; txBuf[2] = 8'h5A; txBuf[3] = 8'h33; xfer(4);
    check("R5 write keeps second byte", rf[32 + 5], 'hA5);

    // R6 bit operations
    wrReg(5'h06, 8'h0F);
    bitOp(1, 5'h06, 8'hF0); check("R6 set", rf[32 + 6], 'hFF);
    bitOp(0, 5'h06, 8'h3C); check("R6 clear", rf[32 + 6], 'hC3);
    wrReg(5'h1F, 8'd2);
    wrReg(5'h03, 8'h55);
    bitOp(1, 5'h03, 8'hAA); check("R6 set ignored on MAC", rf[64 + 3], 'h55);
    bitOp(0, 5'h03, 8'h55); check("R6 clear ignored on MAC", rf[64 + 3], 'h55);
    wrReg(5'h1F, 8'd3);
    wrReg(5'h0A, 8'h11); wrReg(5'h06, 8'h11);
    bitOp(1, 5'h0A, 8'h80); check("R6 set ignored b3 a0A", rf[96 + 10], 'h11);
    bitOp(1, 5'h06, 8'h80); check("R6 set ordinary b3 a06", rf[96 + 6], 'h91);
    bitOp(0, 5'h1F, 8'h02); rdReg(5'h1F, r1, r2);
    check("R6 clear on bank register", r1, 1);

    // R10 pointers, R7 buffer write
    wrReg(5'h1F, 8'd0);
    wrReg(5'h03, 8'hFF); rdReg(5'h03, r1, r2);
    check("R10 high byte truncated", r1, 'h1F);
    wrReg(5'h03, 8'h00); wrReg(5'h02, 8'h10);
    txBuf[0] = 8'h7A;
    for (int i = 0; i < 5; i++) txBuf[1 + i] = 8'(8'hD0 + i);
    xfer(6);
    for (int i = 0; i < 5; i++) check($sformatf("R7 mem[%0h]", 16 + i), mem[16 + i], 'hD0 + i);
    rdReg(5'h02, r1, r2); check("R10 write pointer advanced", r1, 'h15);

    // R8 buffer read
    for (int i = 0; i < 4; i++) mem[32 + i] = 8'(8'h90 + 3 * i);
    wrReg(5'h00, 8'h20); wrReg(5'h01, 8'h00);
    txBuf[0] = 8'h3A;
    for (int i = 1; i < 5; i++) txBuf[i] = 0;
    xfer(5);
    for (int i = 0; i < 4; i++) check($sformatf("R8 byte %0d", i), rxBuf[1 + i], 'h90 + 3 * i);
    rdReg(5'h00, r1, r2); check("R8 read pointer advanced", r1, 'h24);

    // R9 auto-increment off
    wrReg(5'h1E, 8'h00); rdReg(5'h1E, r1, r2); check("R9 control cleared", r1, 0);
    wrReg(5'h02, 8'h40);
    txBuf[0] = 8'h7A; txBuf[1] = 8'h11; txBuf[2] = 8'h22; txBuf[3] = 8'h33; xfer(4);
    check("R9 same location overwritten", mem[64], 'h33);
    check("R9 next location untouched", mem[65], 0);
    rdReg(5'h02, r1, r2); check("R9 write pointer held", r1, 'h40);
    wrReg(5'h00, 8'h20);
    txBuf[0] = 8'h3A; txBuf[1] = 0; txBuf[2] = 0; txBuf[3] = 0; xfer(4);
    check("R9 read repeats", rxBuf[3], 'h90);
    wrReg(5'h1E, 8'h80);

    // R12 aborted bytes
    wrReg(5'h1F, 8'd1); wrReg(5'h07, 8'h77);
    csLow(); sendBits(8'h47, 8, jnk); sendBits(8'h00, 4, jnk); csHigh();
    check("R12 partial byte not written", rf[32 + 7], 'h77);
    csLow(); sendBits(8'h47, 3, jnk); csHigh();
    rdReg(5'h07, r1, r2); check("R12 clean restart", r1, 'h77);

    // R1 unmapped first bytes
    wc = regWrCount; mc = memWrCount;
    txBuf[0] = 8'hC7; txBuf[1] = 8'h00; xfer(2);
    txBuf[0] = 8'h3B; txBuf[1] = 8'hEE; xfer(2);
    txBuf[0] = 8'h20; txBuf[1] = 8'hEE; xfer(2);
    check("R1 no register write", regWrCount, wc);
    check("R1 no memory write", memWrCount, mc);
    rdReg(5'h07, r1, r2); check("R1 register intact", r1, 'h77);

    // R11 soft reset
    wrReg(5'h1F, 8'd0); wrReg(5'h00, 8'h33); wrReg(5'h1F, 8'd3);
    csLow(); sendBits(8'hFF, 8, jnk);
    check("R11 clkReady low after command", clkReady, 0);
    csHigh();
    check("R11 reset pulse", resetPulses, 1);
    repeat (HOLD + 4) @(negedge clk);
    check("R11 clkReady back", clkReady, 1);
    rdReg(5'h1F, r1, r2); check("R11 bank reset", r1, 0);
    rdReg(5'h1E, r1, r2); check("R11 auto control reset", r1, 'h80);
    rdReg(5'h00, r1, r2); check("R11 read pointer reset", r1, 0);
    rdReg(5'h05, r1, r2); check("R11 register file cleared", r1, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule